// File: doc/BRIEF.md
# Byte-wide NOR flash command interpreter

This block models the command logic of a byte-wide NOR flash part as synthesizable RTL. A host reaches it through a synchronous write strobe and a synchronous read strobe that share a 16-bit address and an 8-bit data path. Writes are not stored directly. A decoder walks them through keyed multi-write sequences, and those sequences launch a byte program, a whole-array erase, a permanent write lock on the boot region, or entry to and exit from an identification read mode.

Storage is a small register array. Each cell is selected by a region bit (boot or main) and the low `MEM_AW-1` address bits, so main-region addresses that agree in those low bits alias to one cell. Program and erase take a fixed number of clock cycles set by parameters. While an operation runs, reads return a polling status instead of array contents. A host can therefore find the end of an operation either from the complemented data bit or from the toggling bit.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every cell reads 8'hFF, `busy` is 0, the lock is clear and ID mode is off. A read accepted at a clock edge shows on `rdata` right after that edge, and `rdata` holds its value until the next read.
- R2: The writes AA@5555, 55@2AAA and A0@5555, followed by one write of data D to address X, program cell X. `busy` rises at the edge that accepts the fourth write.
- R3: Programming stores (old AND D). Bits only ever go from 1 to 0, and only an erase sets them back to 1.
- R4: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA and 10@5555 set every cell outside a locked boot region to 8'hFF.
- R5: The same five-write prefix ended by 40@5555 locks addresses 0000 to 1FFF. After that, no program and no erase changes a boot cell, while main cells can still be written.
- R6: The writes AA@5555, 55@2AAA and 90@5555 enter ID mode. In ID mode a read of address 0 gives 1F, address 1 gives 03, address 2 gives the lock state on bit 0 (1 = locked), and any other address gives 00.
- R7: ID mode ends on AA@5555, 55@2AAA, F0@5555, or on a single F0 written to any address.
- R8: A write that does not match the next expected step returns the decoder to idle and changes no cell, mode or lock.
- R9: `busy` stays high for exactly PROG_CYCLES cycles after a program and ERASE_CYCLES cycles after an erase.
- R10: A read while busy returns bit 7 as the complement of bit 7 of the last loaded byte (the program data, or the erase byte 10, so bit 7 reads 1 during an erase). Bit 6 starts at 0 for each operation and inverts on every read. Bits 5..0 read 0.
- R11: Writes accepted while `busy` is high are ignored.
- R12: Once set, the lock stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; restores the factory state |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| addr | input | 16 | Byte address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | High while a program or erase runs |

## Verification
A decoder left in the wrong step shows up at the ports only later: a following command is dropped or wrongly accepted, and the next read of the target cell or of ID address 0 exposes it. A broken busy counter shows in `busy` at once and in the status byte on the very next read. A lost lock flag is reported by ID address 2 and by a boot cell that changes after an erase. Each check therefore ends with a read of a cell or of an ID location that the error would have disturbed.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and types of the flash command interpreter.
// Assumes 16-bit addresses and 8-bit data, fixed by the command set.
package flash_cmd_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555;
    localparam logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA;

    localparam logic [DATA_W-1:0] KEY_BYTE_A   = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_BYTE_B   = 8'h55;
    localparam logic [DATA_W-1:0] OP_PROGRAM   = 8'hA0;
    localparam logic [DATA_W-1:0] OP_EXTEND    = 8'h80;
    localparam logic [DATA_W-1:0] OP_ID_ENTER  = 8'h90;
    localparam logic [DATA_W-1:0] OP_ID_LEAVE  = 8'hF0;
    localparam logic [DATA_W-1:0] OP_ERASE_ALL = 8'h10;
    localparam logic [DATA_W-1:0] OP_LOCK_BOOT = 8'h40;

    localparam logic [DATA_W-1:0] ID_MAKER = 8'h1F;
    localparam logic [DATA_W-1:0] ID_PART  = 8'h03;
    localparam logic [DATA_W-1:0] ERASED   = 8'hFF;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PROG_ARM,
        SQ_EXT1,
        SQ_EXT2,
        SQ_EXT3
    } seq_state_t;

    // True when a write carries the given address and data pair.
    function automatic logic key_hit(input logic [ADDR_W-1:0] a,
                                     input logic [DATA_W-1:0] d,
                                     input logic [ADDR_W-1:0] ea,
                                     input logic [DATA_W-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction
endpackage

// File: rtl/flash_cmd_seq.sv
// Command sequence decoder. It follows the keyed write sequences and
// produces one-cycle launch pulses for program, erase and lock. It also
// owns the ID mode flag. Writes are taken only while no operation is busy.
// Assumes the busy input is registered, so the pulses form no loop.
module flash_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              prog_go,
    output logic              erase_go,
    output logic              lock_go,
    output logic              id_mode
);
    seq_state_t state_q, state_d;
    logic       id_q, id_d;

    // Next-state and launch decode for one accepted write.
    always_comb begin
        state_d  = state_q;
        id_d     = id_q;
        prog_go  = 1'b0;
        erase_go = 1'b0;
        lock_go  = 1'b0;
        if (wr_en && !busy) begin
            state_d = SQ_IDLE;
            unique case (state_q)
                SQ_IDLE: begin
                    if (key_hit(addr, wdata, KEY_ADDR_A, KEY_BYTE_A)) state_d = SQ_KEY1;
                end
                SQ_KEY1: begin
                    if (key_hit(addr, wdata, KEY_ADDR_B, KEY_BYTE_B)) state_d = SQ_KEY2;
                end
                SQ_KEY2: begin
                    if (addr == KEY_ADDR_A) begin
                        if (wdata == OP_PROGRAM)       state_d = SQ_PROG_ARM;
                        else if (wdata == OP_EXTEND)   state_d = SQ_EXT1;
                        else if (wdata == OP_ID_ENTER) id_d = 1'b1;
                        else if (wdata == OP_ID_LEAVE) id_d = 1'b0;
                    end
                end
                SQ_PROG_ARM: prog_go = 1'b1;
                SQ_EXT1: begin
                    if (key_hit(addr, wdata, KEY_ADDR_A, KEY_BYTE_A)) state_d = SQ_EXT2;
                end
                SQ_EXT2: begin
                    if (key_hit(addr, wdata, KEY_ADDR_B, KEY_BYTE_B)) state_d = SQ_EXT3;
                end
                SQ_EXT3: begin
                    if (addr == KEY_ADDR_A) begin
                        if (wdata == OP_ERASE_ALL)      erase_go = 1'b1;
                        else if (wdata == OP_LOCK_BOOT) lock_go  = 1'b1;
                    end
                end
                default: state_d = SQ_IDLE;
            endcase
            // A lone leave byte closes ID mode from any step except program data.
            if (state_q != SQ_PROG_ARM && id_q && wdata == OP_ID_LEAVE) begin
                id_d    = 1'b0;
                state_d = SQ_IDLE;
            end
        end
    end

    // Decoder state and ID flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            id_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    assign id_mode = id_q;
endmodule

// File: rtl/flash_op_timer.sv
// Operation timer. It counts down the busy window of a program or an erase
// and keeps the complemented bit 7 of the byte that started the operation.
// Assumes launches arrive only while idle, which the decoder ensures.
module flash_op_timer
    import flash_cmd_pkg::*;
#(
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_go,
    input  logic erase_go,
    input  logic load_msb,
    output logic busy,
    output logic poll_msb
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             poll_q;

    // Load the window on a launch, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            poll_q <= 1'b0;
        end else if (prog_go) begin
            cnt_q  <= CNT_W'(PROG_CYCLES);
            poll_q <= ~load_msb;
        end else if (erase_go) begin
            cnt_q  <= CNT_W'(ERASE_CYCLES);
            poll_q <= ~OP_ERASE_ALL[DATA_W-1];
        end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy     = (cnt_q != '0);
    assign poll_msb = poll_q;
endmodule

// File: rtl/flash_cell_array.sv
// Storage array with program-by-AND and whole-array erase. A cell index is
// built from a region bit (set above BOOT_LAST) and the low MEM_AW-1
// address bits. While the lock is set, boot cells ignore every change.
module flash_cell_array
    import flash_cmd_pkg::*;
#(
    parameter int                MEM_AW    = 6,
    parameter logic [ADDR_W-1:0] BOOT_LAST = 16'h1FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_go,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_go,
    input  logic              boot_locked,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_byte
);
    localparam int HALF_AW = MEM_AW - 1;
    localparam int DEPTH   = 1 << MEM_AW;
    localparam int HALF    = DEPTH / 2;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [MEM_AW-1:0] prog_idx, rd_idx;

    // Fold a full address onto the array index.
    function automatic logic [MEM_AW-1:0] fold(input logic [ADDR_W-1:0] a);
        return {(a > BOOT_LAST), a[HALF_AW-1:0]};
    endfunction

    assign prog_idx = fold(prog_addr);
    assign rd_idx   = fold(rd_addr);
    assign rd_byte  = mem_q[rd_idx];

    // Per-cell update: reset to erased, erase, or AND-program.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= ERASED;
            end else if (!(boot_locked && (i < HALF))) begin
                if (erase_go)
                    mem_q[i] <= ERASED;
                else if (prog_go && (prog_idx == MEM_AW'(i)))
                    mem_q[i] <= mem_q[i] & prog_data;
            end
        end
    end
endmodule

// File: rtl/flash_read_port.sv
// Read multiplexer with a registered output. While busy it returns the
// polling status, in ID mode the identification bytes, otherwise array data.
// The toggle bit clears at each launch and inverts on each busy read.
module flash_read_port
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              busy,
    input  logic              op_start,
    input  logic              poll_msb,
    input  logic              id_mode,
    input  logic              boot_locked,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] array_byte,
    output logic [DATA_W-1:0] rdata
);
    logic              toggle_q;
    logic [DATA_W-1:0] id_byte, next_byte, rdata_q;

    // Identification byte for the low ID addresses.
    always_comb begin
        unique case (addr)
            16'h0000: id_byte = ID_MAKER;
            16'h0001: id_byte = ID_PART;
            16'h0002: id_byte = {{(DATA_W-1){1'b0}}, boot_locked};
            default:  id_byte = '0;
        endcase
    end

    // Source select for the next read.
    always_comb begin
        if (busy)         next_byte = {poll_msb, toggle_q, {(DATA_W-2){1'b0}}};
        else if (id_mode) next_byte = id_byte;
        else              next_byte = array_byte;
    end

    // Toggle bit: cleared per operation, inverted by each status read.
    always_ff @(posedge clk) begin
        if (!rst_n)             toggle_q <= 1'b0;
        else if (op_start)      toggle_q <= 1'b0;
        else if (rd_en && busy) toggle_q <= ~toggle_q;
    end

    // Output register, loaded only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= next_byte;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command interpreter. It connects the decoder, timer,
// array and read port, and holds the sticky boot lock flag.
// Assumes synchronous strobes, with at most one command write per cycle.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int                MEM_AW       = 6,
    parameter int                PROG_CYCLES  = 8,
    parameter int                ERASE_CYCLES = 24,
    parameter logic [ADDR_W-1:0] BOOT_LAST    = 16'h1FFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        busy
);
    logic              prog_go, erase_go, lock_go, id_mode;
    logic              locked_q, busy_w, poll_msb;
    logic [DATA_W-1:0] array_byte;

    flash_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .busy     (busy_w),
        .addr     (addr),
        .wdata    (wdata),
        .prog_go  (prog_go),
        .erase_go (erase_go),
        .lock_go  (lock_go),
        .id_mode  (id_mode)
    );

    flash_op_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_go  (prog_go),
        .erase_go (erase_go),
        .load_msb (wdata[DATA_W-1]),
        .busy     (busy_w),
        .poll_msb (poll_msb)
    );

    flash_cell_array #(
        .MEM_AW    (MEM_AW),
        .BOOT_LAST (BOOT_LAST)
    ) u_cells (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_go     (prog_go),
        .prog_addr   (addr),
        .prog_data   (wdata),
        .erase_go    (erase_go),
        .boot_locked (locked_q),
        .rd_addr     (addr),
        .rd_byte     (array_byte)
    );

    flash_read_port u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .busy        (busy_w),
        .op_start    (prog_go | erase_go),
        .poll_msb    (poll_msb),
        .id_mode     (id_mode),
        .boot_locked (locked_q),
        .addr        (addr),
        .array_byte  (array_byte),
        .rdata       (rdata)
    );

    // Sticky boot lock: set by its command, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       locked_q <= 1'b0;
        else if (lock_go) locked_q <= 1'b1;
    end

    assign busy = busy_w;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Assertion checker for flash_cmd_ctrl, bound to every instance of it.
// Observes ports together with the decoder state, the lock flag and the cells.
module flash_cmd_ctrl_chk #(
    parameter int MEM_AW = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [15:0] addr,
    input logic [7:0] rdata,
    input logic       busy,
    input logic       id_mode,
    input logic       locked,
    input logic [2:0] seq_state,
    input logic       prog_go,
    input logic       erase_go,
    input logic [7:0] cells [1 << MEM_AW]
);
    localparam int DEPTH = 1 << MEM_AW;

    assert_lock_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(seq_state) && $stable(id_mode) && $stable(locked)));

    assert_status_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> (rdata[5:0] == 6'h00));

    assert_id_maker_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && id_mode && rd_en && addr == 16'h0000) |=> (rdata == 8'h1F));

    assert_prog_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> busy);

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        // R3: without an erase no bit of any cell may rise.
        assert_only_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !erase_go |=> ((cells[i] & ~$past(cells[i])) == 8'h00));
        if (i < DEPTH / 2) begin : g_boot
            // R5: a locked boot cell never changes.
            assert_boot_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
                locked |=> $stable(cells[i]));
        end
    end
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .busy      (busy),
    .id_mode   (id_mode),
    .locked    (locked_q),
    .seq_state (u_seq.state_q),
    .prog_go   (prog_go),
    .erase_go  (erase_go),
    .cells     (u_cells.mem_q)
);

// File: tb/flash_cmd_ctrl_tb.sv
// Directed bench for flash_cmd_ctrl: one task per scenario, each checking itself.
module flash_cmd_ctrl_tb;
    localparam int PROG_CYC  = 8;
    localparam int ERASE_CYC = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy;
    int          checks = 0;
    int          errors = 0;

    flash_cmd_ctrl #(
        .MEM_AW       (6),
        .PROG_CYCLES  (PROG_CYC),
        .ERASE_CYCLES (ERASE_CYC),
        .BOOT_LAST    (16'h1FFF)
    ) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .busy  (busy)
    );

    always #10 clk = ~clk;

    // Tasks start and end at a falling edge.
    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp_v);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic keys();
        do_write(16'h5555, 8'hAA);
        do_write(16'h2AAA, 8'h55);
    endtask

    task automatic program_byte(input logic [15:0] a, input logic [7:0] d);
        keys();
        do_write(16'h5555, 8'hA0);
        do_write(a, d);
    endtask

    task automatic ext_cmd(input logic [7:0] last);
        keys();
        do_write(16'h5555, 8'h80);
        keys();
        do_write(16'h5555, last);
    endtask

    task automatic id_enter();
        keys();
        do_write(16'h5555, 8'h90);
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check8("R1 busy after reset", {7'b0, busy}, 8'h00);
        do_read(16'h0000, d); check8("R1 boot cell erased", d, 8'hFF);
        do_read(16'h3000, d); check8("R1 main cell erased", d, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] d; int n;
        program_byte(16'h2005, 8'h5A);
        check8("R2 busy after fourth write", {7'b0, busy}, 8'h01);
        wait_ready(n);
        check8("R9 program busy length", 8'(n), 8'(PROG_CYC));
        do_read(16'h2005, d); check8("R2 programmed byte", d, 8'h5A);
        addr = 16'h0000;
        repeat (3) @(negedge clk);
        check8("R1 rdata holds without read", rdata, 8'h5A);
    endtask

    task automatic t_and();
        logic [7:0] d; int n;
        program_byte(16'h2005, 8'hF0); wait_ready(n);
        do_read(16'h2005, d); check8("R3 AND of old and new", d, 8'h50);
        program_byte(16'h2005, 8'hFF); wait_ready(n);
        do_read(16'h2005, d); check8("R3 bits cannot rise", d, 8'h50);
    endtask

    task automatic t_status();
        logic [7:0] d; int n;
        program_byte(16'h2006, 8'h3C);
        do_read(16'h2006, d); check8("R10 first status read", d, 8'h80);
        do_read(16'h2006, d); check8("R10 toggled status read", d, 8'hC0);
        wait_ready(n);
        do_read(16'h2006, d); check8("R10 true data after busy", d, 8'h3C);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d; int n;
        program_byte(16'h2007, 8'h81);
        do_read(16'h2007, d); check8("R10 status bit7 complement", d, 8'h00);
        id_enter();
        wait_ready(n);
        do_read(16'h0000, d); check8("R11 ID entry ignored while busy", d, 8'hFF);
        do_read(16'h2007, d); check8("R11 programmed data intact", d, 8'h81);
    endtask

    task automatic t_break();
        logic [7:0] d;
        keys();
        do_write(16'h5555, 8'h33);
        do_write(16'h5555, 8'hA0);
        do_write(16'h2008, 8'h00);
        check8("R8 no busy after broken sequence", {7'b0, busy}, 8'h00);
        do_read(16'h2008, d); check8("R8 bad third byte", d, 8'hFF);
        do_write(16'h5555, 8'hAA);
        do_write(16'h2AA0, 8'h55);
        do_write(16'h5555, 8'hA0);
        do_write(16'h200A, 8'h00);
        do_read(16'h200A, d); check8("R8 bad second address", d, 8'hFF);
    endtask

    task automatic t_id();
        logic [7:0] d;
        id_enter();
        do_read(16'h0000, d); check8("R6 maker code", d, 8'h1F);
        do_read(16'h0001, d); check8("R6 part code", d, 8'h03);
        do_read(16'h0002, d); check8("R6 lock bit clear", d, 8'h00);
        do_read(16'h0005, d); check8("R6 other ID address", d, 8'h00);
        do_write(16'h1234, 8'hF0);
        do_read(16'h0000, d); check8("R7 single-write exit", d, 8'hFF);
        id_enter();
        keys();
        do_write(16'h5555, 8'hF0);
        do_read(16'h0001, d); check8("R7 keyed exit", d, 8'hFF);
    endtask

    task automatic t_erase();
        logic [7:0] d; int n;
        program_byte(16'h0010, 8'h12); wait_ready(n);
        do_read(16'h0010, d); check8("R5 boot writable before lock", d, 8'h12);
        ext_cmd(8'h10);
        do_read(16'h0010, d); check8("R10 erase status", d, 8'h80);
        wait_ready(n);
        check8("R9 erase busy length", 8'(n), 8'(ERASE_CYC - 1));
        do_read(16'h0010, d); check8("R4 boot cell erased", d, 8'hFF);
        do_read(16'h2005, d); check8("R4 main cell erased", d, 8'hFF);
    endtask

    task automatic t_lock();
        logic [7:0] d; int n;
        program_byte(16'h0011, 8'h77); wait_ready(n);
        ext_cmd(8'h40);
        check8("R5 lock starts no busy", {7'b0, busy}, 8'h00);
        program_byte(16'h0011, 8'h00); wait_ready(n);
        do_read(16'h0011, d); check8("R5 locked cell not programmed", d, 8'h77);
        program_byte(16'h2009, 8'h0F); wait_ready(n);
        do_read(16'h2009, d); check8("R5 main still programmable", d, 8'h0F);
        ext_cmd(8'h10); wait_ready(n);
        do_read(16'h0011, d); check8("R5 locked cell not erased", d, 8'h77);
        do_read(16'h2009, d); check8("R4 main erased with lock", d, 8'hFF);
        id_enter();
        do_read(16'h0002, d); check8("R12 lock bit set", d, 8'h01);
        do_write(16'h0000, 8'hF0);
    endtask

    task automatic t_reset_clear();
        logic [7:0] d;
        reset_dut();
        id_enter();
        do_read(16'h0002, d); check8("R12 lock cleared by reset", d, 8'h00);
        do_write(16'h0000, 8'hF0);
        do_read(16'h0011, d); check8("R1 array restored by reset", d, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_and();
        t_status();
        t_busy_ignore();
        t_break();
        t_id();
        t_erase();
        t_lock();
        t_reset_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule